// File: doc/BRIEF.md
# Debug Access Abort and Permission Controller

This block sits between a 32-bit debug register bus and a memory master that runs one transaction at a time. Every debug request names a register index. Some indices are the data window and a small bank of banked-data slots, and an access to one of these starts a system bus transaction. The other indices are answered locally. Before a transaction starts, the block checks it against a debug-enable input and a secure-enable input. Both inputs are sampled through a short register chain. The requested protection level (secure or non-secure) also takes part in the check. A refused transfer is answered with a local slave-error and never reaches the bus.

A debug-side abort completes the debug handshake on the next cycle. The system transaction keeps running. While that orphaned transaction is outstanding, the busy flag stays high. Every access that would start a new bus transaction is refused locally until the bus reports completion. When a slave-error is returned, the busy flag and a separate source flag tell a debugger what caused it: a permission refusal, a system error response, or a refusal that followed an abort.

Top module: `dap_guard`

## Requirements
- R1: A synchronous reset, applied even in mid-transfer, clears busy, ready, slave-error, the error-source flag and bus_start on the next edge. A bus_done that arrives after the reset while nothing is outstanding has no effect.
- R2: A permitted access to the data index (3) or to a banked index (4 to 7) raises bus_start for one cycle, one cycle after the request is sampled. busy is high from that cycle until the cycle after bus_done is sampled.
- R3: When a bus transfer completes with bus_err high, ready, slave-error and err_sys are high together one cycle later, and busy is low in that cycle.
- R4: A read that completes carries bus_rdata onto dbg_rdata in the ready cycle. A completed write returns zero data. bus_write, bus_nonsec and bus_wdata reflect the request in the bus_start cycle.
- R5: With registered debug-enable low, a bus-register access gets ready and slave-error one cycle later, with err_sys low and no bus_start.
- R6: A secure access (dbg_nonsec=0) while registered secure-enable is low is refused locally in the same way as R5. A non-secure access with debug-enable high is issued whatever the value of secure-enable.
- R7: Both enable inputs pass through SYNC_STAGES (default 2) registers, and only the delayed values decide permission. An enable changed one cycle before a request does not yet affect that request.
- R8: dbg_abort gives ready exactly one cycle later with slave-error low. If a transfer is outstanding, busy stays high.
- R9: After an abort, while busy is high, any access to a bus index returns slave-error one cycle later with busy high and err_sys low, and starts no transfer.
- R10: A bus_done for an aborted transfer clears busy without producing a debug-side ready. Later accesses are then issued normally.
- R11: Accesses to indices that are not bus registers complete one cycle later without error, including after an abort. A read of the control index (0) returns busy in bit 7.
- R12: If dbg_abort and bus_done arrive in the same cycle, the transfer completes normally: ready and the bus error status come one cycle later, and busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en_in | input | 1 | Debug-enable, sampled through a register chain |
| sec_en_in | input | 1 | Secure-enable, sampled through a register chain |
| dbg_req | input | 1 | One-cycle debug request strobe |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | ADDR_W | Register index |
| dbg_nonsec | input | 1 | Protection: 1 = non-secure, 0 = secure |
| dbg_wdata | input | DATA_W | Write data |
| dbg_abort | input | 1 | One-cycle abort strobe |
| dbg_ready | output | 1 | One-cycle completion strobe |
| dbg_slverr | output | 1 | Error with completion |
| dbg_rdata | output | DATA_W | Read data with completion |
| err_sys | output | 1 | Slave-error came from the system bus |
| xfer_busy | output | 1 | Transfer-in-progress flag |
| bus_start | output | 1 | One-cycle start of a bus transaction |
| bus_write | output | 1 | Direction of the started transaction |
| bus_nonsec | output | 1 | Protection of the started transaction |
| bus_wdata | output | DATA_W | Write data of the started transaction |
| bus_done | input | 1 | Bus transaction completed |
| bus_err | input | 1 | Error response with bus_done |
| bus_rdata | input | DATA_W | Read data with bus_done |

## Verification
The hardest state to reach is the orphan window: an abort has completed the debug handshake, but the system transaction is still open. The bench acts as the bus itself and withholds bus_done for several cycles after the abort. During that gap it fires bus-register reads and writes and a control read. It then lets the late bus_done arrive, and also lines up an abort and a bus_done in the same cycle. Enable changes are placed one cycle before a request so that the register delay decides the outcome.

// File: rtl/dap_guard_pkg.sv
package dap_guard_pkg;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_WAIT,
    XS_ORPHAN
  } xfer_state_e;

  typedef enum logic [1:0] {
    GATE_LOCAL,
    GATE_ISSUE,
    GATE_DENY,
    GATE_BLOCKED
  } gate_e;

endpackage

// File: rtl/enable_sampler.sv
module enable_sampler #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d_in;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_out = chain[STAGES-1];

endmodule

// File: rtl/access_gate.sv
module access_gate
  import dap_guard_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_IDX  = 3,
  parameter int BANK_BASE = 4,
  parameter int BANK_CNT  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              nonsec,
  input  logic              dbg_en_q,
  input  logic              sec_en_q,
  input  logic              orphan,
  output gate_e             verdict
);

  localparam logic [ADDR_W-1:0] DATA_A  = ADDR_W'(DATA_IDX);
  localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] BANK_HI = ADDR_W'(BANK_BASE + BANK_CNT - 1);

  logic hits_bus;
  logic allowed;

  assign hits_bus = (addr == DATA_A) || ((addr >= BANK_LO) && (addr <= BANK_HI));
  assign allowed  = dbg_en_q && (nonsec || sec_en_q);

  always_comb begin
    if (!hits_bus)     verdict = GATE_LOCAL;
    else if (orphan)   verdict = GATE_BLOCKED;
    else if (!allowed) verdict = GATE_DENY;
    else               verdict = GATE_ISSUE;
  end

endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
  import dap_guard_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int CTRL_IDX = 0,
  parameter int BUSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              nonsec,
  input  logic [DATA_W-1:0] wdata,
  input  logic              abort,
  input  gate_e             verdict,
  input  logic              bus_done,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              orphan,
  output logic              busy,
  output logic              ready,
  output logic              slverr,
  output logic              sys_err,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_start,
  output logic              bus_write,
  output logic              bus_nonsec,
  output logic [DATA_W-1:0] bus_wdata
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);

  xfer_state_e       state;
  logic              pend_write;
  logic [DATA_W-1:0] ctrl_word;

  assign orphan = (state == XS_ORPHAN);
  assign busy   = (state != XS_IDLE);

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BUSY_BIT] = orphan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= XS_IDLE;
      pend_write <= 1'b0;
      ready      <= 1'b0;
      slverr     <= 1'b0;
      sys_err    <= 1'b0;
      rdata      <= '0;
      bus_start  <= 1'b0;
      bus_write  <= 1'b0;
      bus_nonsec <= 1'b0;
      bus_wdata  <= '0;
    end else begin
      ready     <= 1'b0;
      slverr    <= 1'b0;
      sys_err   <= 1'b0;
      rdata     <= '0;
      bus_start <= 1'b0;
      if (state == XS_WAIT) begin
        if (bus_done) begin
          ready   <= 1'b1;
          slverr  <= bus_err;
          sys_err <= bus_err;
          rdata   <= pend_write ? '0 : bus_rdata;
          state   <= XS_IDLE;
        end else if (abort) begin
          ready <= 1'b1;
          state <= XS_ORPHAN;
        end
      end else begin
        if (orphan && bus_done) begin
          state <= XS_IDLE;
        end
        if (abort) begin
          ready <= 1'b1;
        end else if (req) begin
          unique case (verdict)
            GATE_LOCAL: begin
              ready <= 1'b1;
              rdata <= (!write && addr == CTRL_A) ? ctrl_word : '0;
            end
            GATE_DENY, GATE_BLOCKED: begin
              ready  <= 1'b1;
              slverr <= 1'b1;
            end
            GATE_ISSUE: begin
              bus_start  <= 1'b1;
              bus_write  <= write;
              bus_nonsec <= nonsec;
              bus_wdata  <= wdata;
              pend_write <= write;
              state      <= XS_WAIT;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dap_guard.sv
module dap_guard
  import dap_guard_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_IDX    = 0,
  parameter int DATA_IDX    = 3,
  parameter int BANK_BASE   = 4,
  parameter int BANK_CNT    = 4,
  parameter int BUSY_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_en_in,
  input  logic              sec_en_in,
  input  logic              dbg_req,
  input  logic              dbg_write,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_nonsec,
  input  logic [DATA_W-1:0] dbg_wdata,
  input  logic              dbg_abort,
  output logic              dbg_ready,
  output logic              dbg_slverr,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              err_sys,
  output logic              xfer_busy,
  output logic              bus_start,
  output logic              bus_write,
  output logic              bus_nonsec,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic [1:0] en_q;
  logic       orphan;
  gate_e      verdict;

  enable_sampler #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sampler (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({sec_en_in, dbg_en_in}),
    .q_out (en_q)
  );

  access_gate #(
    .ADDR_W(ADDR_W), .DATA_IDX(DATA_IDX), .BANK_BASE(BANK_BASE), .BANK_CNT(BANK_CNT)
  ) u_gate (
    .addr     (dbg_addr),
    .nonsec   (dbg_nonsec),
    .dbg_en_q (en_q[0]),
    .sec_en_q (en_q[1]),
    .orphan   (orphan),
    .verdict  (verdict)
  );

  xfer_tracker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX), .BUSY_BIT(BUSY_BIT)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .req        (dbg_req),
    .write      (dbg_write),
    .addr       (dbg_addr),
    .nonsec     (dbg_nonsec),
    .wdata      (dbg_wdata),
    .abort      (dbg_abort),
    .verdict    (verdict),
    .bus_done   (bus_done),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .orphan     (orphan),
    .busy       (xfer_busy),
    .ready      (dbg_ready),
    .slverr     (dbg_slverr),
    .sys_err    (err_sys),
    .rdata      (dbg_rdata),
    .bus_start  (bus_start),
    .bus_write  (bus_write),
    .bus_nonsec (bus_nonsec),
    .bus_wdata  (bus_wdata)
  );

endmodule

// File: rtl/dap_guard_chk.sv
module dap_guard_chk (
  input logic clk,
  input logic rst,
  input logic dbg_abort,
  input logic dbg_ready,
  input logic dbg_slverr,
  input logic err_sys,
  input logic xfer_busy,
  input logic bus_start,
  input logic bus_done
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!xfer_busy && !dbg_ready && !bus_start && !err_sys));

  assert_busy_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && !bus_done) |=> xfer_busy);

  assert_sys_err_shape_R3: assert property (@(posedge clk) disable iff (rst)
    err_sys |-> (dbg_ready && dbg_slverr && !xfer_busy));

  assert_abort_ready_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_abort |=> dbg_ready);

  assert_no_start_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    bus_start |-> (xfer_busy && !$past(xfer_busy)));

  assert_busy_err_is_local_R9: assert property (@(posedge clk) disable iff (rst)
    (dbg_slverr && xfer_busy) |-> !err_sys);

endmodule

bind dap_guard dap_guard_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dbg_abort  (dbg_abort),
  .dbg_ready  (dbg_ready),
  .dbg_slverr (dbg_slverr),
  .err_sys    (err_sys),
  .xfer_busy  (xfer_busy),
  .bus_start  (bus_start),
  .bus_done   (bus_done)
);

// File: tb/tb_dap_guard.sv
module tb_dap_guard;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_en_in = 1'b0, sec_en_in = 1'b0;
  logic        dbg_req = 1'b0, dbg_write = 1'b0, dbg_nonsec = 1'b0, dbg_abort = 1'b0;
  logic [5:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic        bus_done = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        dbg_ready, dbg_slverr, err_sys, xfer_busy;
  logic        bus_start, bus_write, bus_nonsec;
  logic [31:0] dbg_rdata, bus_wdata;

  int    total = 0, bad = 0, cyc = 0;
  string phase = "R1 reset";
  bit    started = 0;

  always #2 clk = ~clk;

  dap_guard #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .dbg_en_in(dbg_en_in), .sec_en_in(sec_en_in),
    .dbg_req(dbg_req), .dbg_write(dbg_write), .dbg_addr(dbg_addr),
    .dbg_nonsec(dbg_nonsec), .dbg_wdata(dbg_wdata), .dbg_abort(dbg_abort),
    .dbg_ready(dbg_ready), .dbg_slverr(dbg_slverr), .dbg_rdata(dbg_rdata),
    .err_sys(err_sys), .xfer_busy(xfer_busy), .bus_start(bus_start),
    .bus_write(bus_write), .bus_nonsec(bus_nonsec), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference model: behaviour taken from the requirements
  logic        m_busy = 0, m_orph = 0, m_w = 0;
  logic        e_ready = 0, e_err = 0, e_sys = 0, e_start = 0, e_bw = 0, e_bns = 0;
  logic [31:0] e_rdata = 0, e_bwd = 0;
  logic [1:0]  hist [SYNC];
  logic        o_busy, o_orph, isbus, en_ok, sec_ok;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_busy = 0; m_orph = 0; m_w = 0;
      e_ready = 0; e_err = 0; e_sys = 0; e_start = 0; e_rdata = 0;
      for (int i = 0; i < SYNC; i++) hist[i] = 2'b00;
    end else begin
      o_busy = m_busy; o_orph = m_orph;
      en_ok  = hist[SYNC-1][0];
      sec_ok = hist[SYNC-1][1];
      for (int i = SYNC - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {sec_en_in, dbg_en_in};
      e_ready = 0; e_err = 0; e_sys = 0; e_start = 0; e_rdata = 0;
      if (o_busy && !o_orph) begin
        if (bus_done) begin
          e_ready = 1; e_err = bus_err; e_sys = bus_err;
          e_rdata = m_w ? 32'h0 : bus_rdata;
          m_busy = 0;
        end else if (dbg_abort) begin
          e_ready = 1; m_orph = 1;
        end
      end else begin
        if (o_orph && bus_done) begin
          m_busy = 0; m_orph = 0;
        end
        if (dbg_abort) begin
          e_ready = 1;
        end else if (dbg_req) begin
          isbus = (dbg_addr == 6'd3) || (dbg_addr >= 6'd4 && dbg_addr <= 6'd7);
          if (!isbus) begin
            e_ready = 1;
            e_rdata = (!dbg_write && dbg_addr == 6'd0) ? {24'h0, o_orph, 7'h0} : 32'h0;
          end else if (o_orph || !en_ok || (!dbg_nonsec && !sec_ok)) begin
            e_ready = 1; e_err = 1;
          end else begin
            e_start = 1; e_bw = dbg_write; e_bns = dbg_nonsec; e_bwd = dbg_wdata;
            m_busy = 1; m_w = dbg_write;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk({phase, " ready"}, {31'h0, dbg_ready}, {31'h0, e_ready});
      chk({phase, " slverr"}, {31'h0, dbg_slverr}, {31'h0, e_err});
      chk({phase, " err_sys"}, {31'h0, err_sys}, {31'h0, e_sys});
      chk({phase, " busy"}, {31'h0, xfer_busy}, {31'h0, m_busy});
      chk({phase, " start"}, {31'h0, bus_start}, {31'h0, e_start});
      if (e_ready) chk({phase, " rdata"}, dbg_rdata, e_rdata);
      if (e_start) begin
        chk({phase, " bus_write"}, {31'h0, bus_write}, {31'h0, e_bw});
        chk({phase, " bus_nonsec"}, {31'h0, bus_nonsec}, {31'h0, e_bns});
        chk({phase, " bus_wdata"}, bus_wdata, e_bwd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<5000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [5:0] a, input logic w, input logic ns, input logic [31:0] wd);
    @(negedge clk);
    dbg_req = 1; dbg_addr = a; dbg_write = w; dbg_nonsec = ns; dbg_wdata = wd;
    @(negedge clk);
    dbg_req = 0;
  endtask

  task automatic abort_pulse(input logic with_done, input logic err);
    @(negedge clk);
    dbg_abort = 1; bus_done = with_done; bus_err = err;
    @(negedge clk);
    dbg_abort = 0; bus_done = 0; bus_err = 0;
  endtask

  task automatic finish_bus(input logic err, input logic [31:0] rd);
    @(negedge clk);
    bus_done = 1; bus_err = err; bus_rdata = rd;
    @(negedge clk);
    bus_done = 0; bus_err = 0; bus_rdata = 0;
  endtask

  initial begin
    idle(3);
    chk("R1 busy after reset", {31'h0, xfer_busy}, 32'h0);
    chk("R1 ready after reset", {31'h0, dbg_ready}, 32'h0);
    rst = 0;
    dbg_en_in = 1; sec_en_in = 1;
    idle(4);

    phase = "R2 R4 read";
    access(6'd3, 0, 0, 32'h0);
    chk("R2 start", {31'h0, bus_start}, 32'h1);
    idle(3);
    finish_bus(0, 32'hA5A51234);
    chk("R4 rdata", dbg_rdata, 32'hA5A51234);
    chk("R2 busy clear", {31'h0, xfer_busy}, 32'h0);

    phase = "R3 system error";
    access(6'd5, 1, 1, 32'hCAFE0001);
    chk("R4 wdata", bus_wdata, 32'hCAFE0001);
    idle(2);
    finish_bus(1, 32'h0);
    chk("R3 err_sys", {31'h0, err_sys}, 32'h1);

    phase = "R5 debug disabled";
    dbg_en_in = 0;
    idle(4);
    access(6'd3, 0, 1, 32'h0);
    chk("R5 slverr", {31'h0, dbg_slverr}, 32'h1);
    chk("R5 no start", {31'h0, bus_start}, 32'h0);

    phase = "R6 secure gate";
    dbg_en_in = 1; sec_en_in = 0;
    idle(4);
    access(6'd4, 0, 0, 32'h0);
    chk("R6 secure refused", {31'h0, dbg_slverr}, 32'h1);
    access(6'd7, 0, 1, 32'h0);
    chk("R6 nonsec issued", {31'h0, bus_start}, 32'h1);
    idle(1);
    finish_bus(0, 32'h00000077);

    phase = "R7 enable delay";
    sec_en_in = 1;
    access(6'd3, 0, 0, 32'h0);
    chk("R7 late enable refused", {31'h0, dbg_slverr}, 32'h1);
    idle(3);
    access(6'd3, 0, 0, 32'h0);
    chk("R7 enable seen", {31'h0, bus_start}, 32'h1);
    finish_bus(0, 32'h12340000);

    phase = "R8 R9 abort";
    access(6'd3, 0, 1, 32'h0);
    idle(2);
    abort_pulse(0, 0);
    chk("R8 ready", {31'h0, dbg_ready}, 32'h1);
    chk("R8 busy held", {31'h0, xfer_busy}, 32'h1);
    access(6'd3, 0, 1, 32'h0);
    chk("R9 read blocked", {31'h0, dbg_slverr}, 32'h1);
    access(6'd6, 1, 1, 32'h55);
    chk("R9 write blocked", {31'h0, dbg_slverr}, 32'h1);
    phase = "R11 control read";
    access(6'd0, 0, 1, 32'h0);
    chk("R11 busy bit", dbg_rdata, 32'h80);
    access(6'd1, 1, 1, 32'h9);
    chk("R11 other reg ok", {31'h0, dbg_slverr}, 32'h0);
    abort_pulse(0, 0);
    phase = "R10 late done";
    idle(2);
    finish_bus(1, 32'hFFFFFFFF);
    chk("R10 busy clear", {31'h0, xfer_busy}, 32'h0);
    chk("R10 no ready", {31'h0, dbg_ready}, 32'h0);
    access(6'd0, 0, 1, 32'h0);
    chk("R11 busy bit clear", dbg_rdata, 32'h0);
    access(6'd4, 1, 0, 32'h0BADF00D);
    chk("R10 issued again", {31'h0, bus_start}, 32'h1);
    finish_bus(0, 32'h0);

    phase = "R12 abort with done";
    access(6'd3, 0, 1, 32'h0);
    idle(1);
    bus_rdata = 32'h00C0FFEE;
    abort_pulse(1, 1);
    bus_rdata = 0;
    chk("R12 busy clear", {31'h0, xfer_busy}, 32'h0);
    chk("R12 sys error", {31'h0, err_sys}, 32'h1);

    phase = "R1 mid reset";
    access(6'd5, 0, 1, 32'h0);
    idle(1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 busy cleared", {31'h0, xfer_busy}, 32'h0);
    idle(3);
    finish_bus(1, 32'h1);
    chk("R1 stray done ignored", {31'h0, dbg_ready}, 32'h0);
    idle(3);
    access(6'd3, 0, 1, 32'h0);
    chk("R1 issue after reset", {31'h0, bus_start}, 32'h1);
    finish_bus(0, 32'h2);
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule